// File: doc/BRIEF.md
# Environment-Controlled Memory Address Decoder

This block sits between a 6502-style CPU with a 16-bit address bus and the memory system behind it. For every address it names exactly one target: a relocatable zero page, the stack page, fixed RAM windows, a banked RAM window, an I/O page, ROM, two peripheral register windows, or nothing at all. For RAM targets it also produces the physical RAM address and a write enable that already has the protection rules applied. When a read reaches nothing, it supplies the fill byte that the read-data mux should return.

Three internal byte registers steer the mapping. A mode register turns the I/O page on or off, write-protects the upper system RAM, swaps ROM in at the top 4 KB and picks the CPU clock rate. A page register moves the zero page anywhere in the low 64 KB of RAM. A bank register selects which 32 KB RAM bank shows through the banked window. The two peripheral windows near the top of memory stay visible in every mode. All decode outputs are combinational from the address and the registers. A register write changes the mapping from the next clock edge.

Top module: `env_addr_decoder`

## Requirements
- R1: `region_sel` has at most one bit set for any address, with bit positions 0 zero page, 1 stack, 2 low RAM, 3 banked RAM, 4 high RAM, 5 system RAM, 6 I/O, 7 ROM, 8 peripheral 0, 9 peripheral 1. `region_valid` is 1 exactly when a bit is set. Both are valid in the same cycle as the address.
- R2: Addresses 0x0000-0x00FF select the zero page, and `ram_addr` = page register × 0x100 + the low address byte.
- R3: 0x0100-0x01FF (stack), 0x0200-0x1FFF (low) and 0xA000-0xBFFF (high) always map to RAM. These and every system-RAM access give `ram_addr` = 0xF0000 + address (default `SYS_SEG` = 15).
- R4: 0x2000-0x9FFF selects banked RAM, with `ram_addr` = bank register[4:0] × 0x8000 + (address − 0x2000).
- R5: Mode bit 6 set makes 0xC000-0xC0FF the I/O region. In that mode 0xC100-0xC4FF and 0xC800-0xCFFF select nothing, and writes there raise no RAM write. With bit 6 clear, all of 0xC000-0xCFFF is system RAM.
- R6: 0xC500-0xC7FF and 0xD000-0xEFFF are system RAM in every mode. Mode bit 3 set blocks `ram_we` for every system-RAM address from 0xC000 up, while `ram_en` stays set.
- R7: Mode bit 0 set makes 0xF000-0xFFFF, outside the peripheral windows, the ROM region, and no RAM write occurs there. With bit 0 clear that range is system RAM, writable unless bit 3 is set.
- R8: 0xFFD0-0xFFDF selects peripheral 0 and 0xFFE0-0xFFEF selects peripheral 1, whatever the mode. These windows never raise `ram_we`.
- R9: Reset sets the mode register to 0xFF, the page register to 0xFF and the bank register to 0x00. A write with `cfg_we` high loads `cfg_wdata` into the mode register (`cfg_sel` 0), the page register (1) or the bank register (2); `cfg_sel` 3 is ignored. The new value governs decoding from the clock edge that takes the write, not before.
- R10: `slow_mode` equals mode bit 7.
- R11: `rd_fill` is 0xFF during a read (`cpu_en` 1, `cpu_we` 0) that selects no region, and 0x00 otherwise. `ram_en` and `ram_we` are 0 while `cpu_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 zero-page page, 2 bank |
| cfg_wdata | input | 8 | Register write data |
| cpu_en | input | 1 | CPU access in progress |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| region_sel | output | 10 | One-hot target select |
| region_valid | output | 1 | Some target responds |
| ram_en | output | 1 | Access goes to RAM |
| ram_we | output | 1 | RAM write after protection |
| ram_addr | output | 20 | Physical RAM address |
| rd_fill | output | 8 | Read data when nothing responds |
| slow_mode | output | 1 | 1 MHz CPU clock requested |

## Verification
Every decode output is due in the same cycle as the address and register state that produce it. The bench drives an access just after a falling edge and samples 1 ns later, well before the next rising edge. A register write is due one rising edge after it is presented. The bench therefore checks the old mapping while the write is still pending, then checks the new mapping just after the edge that takes it. Reset values are checked through the mapping they produce before any register write.

// File: rtl/env_addr_decoder_pkg.sv
package env_addr_decoder_pkg;

    // One-hot region bit positions
    typedef enum int unsigned {
        RG_ZP   = 0,
        RG_STK  = 1,
        RG_LOW  = 2,
        RG_BANK = 3,
        RG_HIGH = 4,
        RG_SYS  = 5,
        RG_IO   = 6,
        RG_ROM  = 7,
        RG_P0   = 8,
        RG_P1   = 9
    } region_idx_e;

    localparam int NUM_REGIONS = 10;
    typedef logic [NUM_REGIONS-1:0] region_vec_t;

    // Regions served by RAM: zero page .. system RAM (bits 0..5)
    localparam region_vec_t RAM_MASK = region_vec_t'(10'b00_0011_1111);

    // Mode register laid out by bit position
    typedef struct packed {
        logic       slow;     // bit 7
        logic       io_on;    // bit 6
        logic [1:0] rsvd_hi;  // bits 5:4
        logic       wprot;    // bit 3
        logic [1:0] rsvd_lo;  // bits 2:1
        logic       rom_on;   // bit 0
    } env_ctl_t;

    typedef enum logic [1:0] {
        CFG_ENV  = 2'd0,
        CFG_ZP   = 2'd1,
        CFG_BANK = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    // Last address of each window
    localparam logic [15:0] ZP_LAST    = 16'h00FF;
    localparam logic [15:0] STK_LAST   = 16'h01FF;
    localparam logic [15:0] LOW_LAST   = 16'h1FFF;
    localparam logic [15:0] BANK_FIRST = 16'h2000;
    localparam logic [15:0] BANK_LAST  = 16'h9FFF;
    localparam logic [15:0] HIGH_LAST  = 16'hBFFF;
    localparam logic [15:0] IOP_LAST   = 16'hC0FF;
    localparam logic [15:0] SLOTA_LAST = 16'hC4FF;
    localparam logic [15:0] SLOTB_LAST = 16'hC7FF;
    localparam logic [15:0] EXP_LAST   = 16'hCFFF;
    localparam logic [15:0] MID_LAST   = 16'hEFFF;
    localparam logic [15:0] P0_FIRST   = 16'hFFD0;
    localparam logic [15:0] P0_LAST    = 16'hFFDF;
    localparam logic [15:0] P1_FIRST   = 16'hFFE0;
    localparam logic [15:0] P1_LAST    = 16'hFFEF;

    localparam logic [7:0] ENV_RESET  = 8'hFF;
    localparam logic [7:0] ZP_RESET   = 8'hFF;
    localparam logic [7:0] BANK_RESET = 8'h00;

    function automatic logic in_window(input logic [15:0] a,
                                       input logic [15:0] lo,
                                       input logic [15:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/adec_cfg_regs.sv
module adec_cfg_regs
    import env_addr_decoder_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    output env_ctl_t   env_q,
    output logic [7:0] zp_q,
    output logic [7:0] bank_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            env_q  <= env_ctl_t'(ENV_RESET);
            zp_q   <= ZP_RESET;
            bank_q <= BANK_RESET;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_ENV:  env_q  <= env_ctl_t'(cfg_wdata);
                CFG_ZP:   zp_q   <= cfg_wdata;
                CFG_BANK: bank_q <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    assert_reset_vals_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (8'(env_q) == ENV_RESET && zp_q == ZP_RESET && bank_q == BANK_RESET));

    assert_env_load_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && $past(cfg_sel) == 2'd0) |-> (8'(env_q) == $past(cfg_wdata)));

    assert_sel3_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we) && $past(cfg_sel) == 2'd3) |->
        ($stable(env_q) && $stable(zp_q) && $stable(bank_q)));

endmodule

// File: rtl/adec_region.sv
module adec_region
    import env_addr_decoder_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  env_ctl_t    ctl,
    output region_vec_t hit,
    output logic        wr_guard
);

    always_comb begin
        hit      = '0;
        wr_guard = 1'b0;
        if (addr <= ZP_LAST) begin
            hit[RG_ZP] = 1'b1;
        end else if (addr <= STK_LAST) begin
            hit[RG_STK] = 1'b1;
        end else if (addr <= LOW_LAST) begin
            hit[RG_LOW] = 1'b1;
        end else if (addr <= BANK_LAST) begin
            hit[RG_BANK] = 1'b1;
        end else if (addr <= HIGH_LAST) begin
            hit[RG_HIGH] = 1'b1;
        end else if (addr <= IOP_LAST) begin
            if (ctl.io_on) begin
                hit[RG_IO] = 1'b1;
            end else begin
                hit[RG_SYS] = 1'b1;
                wr_guard    = ctl.wprot;
            end
        end else if (addr <= SLOTA_LAST) begin
            // hole while I/O is mapped
            if (!ctl.io_on) begin
                hit[RG_SYS] = 1'b1;
                wr_guard    = ctl.wprot;
            end
        end else if (addr <= SLOTB_LAST) begin
            hit[RG_SYS] = 1'b1;
            wr_guard    = ctl.wprot;
        end else if (addr <= EXP_LAST) begin
            if (!ctl.io_on) begin
                hit[RG_SYS] = 1'b1;
                wr_guard    = ctl.wprot;
            end
        end else if (addr <= MID_LAST) begin
            hit[RG_SYS] = 1'b1;
            wr_guard    = ctl.wprot;
        end else if (in_window(addr, P0_FIRST, P0_LAST)) begin
            hit[RG_P0] = 1'b1;
        end else if (in_window(addr, P1_FIRST, P1_LAST)) begin
            hit[RG_P1] = 1'b1;
        end else if (ctl.rom_on) begin
            hit[RG_ROM] = 1'b1;
        end else begin
            hit[RG_SYS] = 1'b1;
            wr_guard    = ctl.wprot | ctl.rom_on;
        end
    end

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    assert_io_hole_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.io_on && (in_window(addr, 16'hC100, 16'hC4FF) || in_window(addr, 16'hC800, 16'hCFFF)))
        |-> (hit == '0));

    assert_periph0_R8: assert property (@(posedge clk) disable iff (rst)
        in_window(addr, 16'hFFD0, 16'hFFDF) |-> hit[RG_P0]);

    assert_periph1_R8: assert property (@(posedge clk) disable iff (rst)
        in_window(addr, 16'hFFE0, 16'hFFEF) |-> hit[RG_P1]);

endmodule

// File: rtl/adec_xlate.sv
module adec_xlate
    import env_addr_decoder_pkg::*;
#(
    parameter int RAM_AW  = 20,
    parameter int SYS_SEG = 15
) (
    input  region_vec_t       hit,
    input  logic [15:0]       addr,
    input  logic [7:0]        zp_page,
    input  logic [7:0]        bank,
    output logic [RAM_AW-1:0] ram_addr
);

    localparam int SEG_W  = RAM_AW - 16;
    localparam int OFF_W  = 15;
    localparam int BANK_W = RAM_AW - OFF_W;

    localparam logic [SEG_W-1:0] SEG = SEG_W'(SYS_SEG);

    logic [OFF_W-1:0]  bank_off;
    logic [BANK_W-1:0] bank_sel;

    assign bank_off = OFF_W'(addr - BANK_FIRST);
    assign bank_sel = bank[BANK_W-1:0];

    always_comb begin
        ram_addr = '0;
        if (hit[RG_ZP]) begin
            ram_addr = RAM_AW'({zp_page, addr[7:0]});
        end else if (hit[RG_BANK]) begin
            ram_addr = {bank_sel, bank_off};
        end else if (hit[RG_STK] || hit[RG_LOW] || hit[RG_HIGH] || hit[RG_SYS]) begin
            ram_addr = {SEG, addr};
        end
    end

endmodule

// File: rtl/env_addr_decoder.sv
module env_addr_decoder
    import env_addr_decoder_pkg::*;
#(
    parameter int         RAM_AW    = 20,
    parameter int         SYS_SEG   = 15,
    parameter logic [7:0] FILL_BYTE = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [7:0]             cfg_wdata,
    input  logic                   cpu_en,
    input  logic                   cpu_we,
    input  logic [15:0]            cpu_addr,
    output logic [NUM_REGIONS-1:0] region_sel,
    output logic                   region_valid,
    output logic                   ram_en,
    output logic                   ram_we,
    output logic [RAM_AW-1:0]      ram_addr,
    output logic [7:0]             rd_fill,
    output logic                   slow_mode
);

    env_ctl_t    env_q;
    logic [7:0]  zp_q;
    logic [7:0]  bank_q;
    region_vec_t hit;
    logic        wr_guard;

    adec_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .env_q     (env_q),
        .zp_q      (zp_q),
        .bank_q    (bank_q)
    );

    adec_region u_region (
        .clk      (clk),
        .rst      (rst),
        .addr     (cpu_addr),
        .ctl      (env_q),
        .hit      (hit),
        .wr_guard (wr_guard)
    );

    adec_xlate #(
        .RAM_AW  (RAM_AW),
        .SYS_SEG (SYS_SEG)
    ) u_xlate (
        .hit      (hit),
        .addr     (cpu_addr),
        .zp_page  (zp_q),
        .bank     (bank_q),
        .ram_addr (ram_addr)
    );

    logic ram_hit;
    assign ram_hit      = |(hit & RAM_MASK);
    assign region_sel   = hit;
    assign region_valid = |hit;
    assign ram_en       = cpu_en & ram_hit;
    assign ram_we       = cpu_en & ram_hit & cpu_we & ~wr_guard;
    assign rd_fill      = (cpu_en && !cpu_we && !(|hit)) ? FILL_BYTE : 8'h00;
    assign slow_mode    = env_q.slow;

    assert_wprot_R6: assert property (@(posedge clk) disable iff (rst)
        (ram_we && env_q.wprot) |-> (cpu_addr < 16'hC000));

    assert_rom_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        (env_q.rom_on && cpu_addr >= 16'hF000) |-> !ram_we);

    assert_zp_reloc_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr <= 16'h00FF) |-> (ram_addr == RAM_AW'({zp_q, cpu_addr[7:0]})));

    assert_fill_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_fill != 8'h00) |-> (!region_valid && cpu_en && !cpu_we));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !cpu_en |-> (!ram_en && !ram_we));

endmodule

// File: tb/env_addr_decoder_tb.sv
`timescale 1ns/100ps
module env_addr_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        cpu_en = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [9:0]  region_sel;
    logic        region_valid;
    logic        ram_en;
    logic        ram_we;
    logic [19:0] ram_addr;
    logic [7:0]  rd_fill;
    logic        slow_mode;

    always #2.5 clk = ~clk;

    env_addr_decoder u_dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .cpu_en       (cpu_en),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .region_sel   (region_sel),
        .region_valid (region_valid),
        .ram_en       (ram_en),
        .ram_we       (ram_we),
        .ram_addr     (ram_addr),
        .rd_fill      (rd_fill),
        .slow_mode    (slow_mode)
    );

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  done     = 1'b0;

    // Region codes from R1
    localparam logic [9:0] B_NO = 10'h000;
    localparam logic [9:0] B_ZP = 10'h001;
    localparam logic [9:0] B_ST = 10'h002;
    localparam logic [9:0] B_LO = 10'h004;
    localparam logic [9:0] B_BK = 10'h008;
    localparam logic [9:0] B_HI = 10'h010;
    localparam logic [9:0] B_SY = 10'h020;
    localparam logic [9:0] B_IO = 10'h040;
    localparam logic [9:0] B_RM = 10'h080;
    localparam logic [9:0] B_P0 = 10'h100;
    localparam logic [9:0] B_P1 = 10'h200;

    localparam logic [7:0] ZP_T   = 8'h12;
    localparam logic [7:0] BANK_T = 8'h03;

    // {mode, write, address, region, expected ram_we, expected fill}
    localparam int NV = 46;
    localparam logic [43:0] VEC [NV] = '{
        // mode 0x00: no I/O, no protection, RAM at top
        {8'h00,1'b0,16'h0000,B_ZP,1'b0,8'h00},
        {8'h00,1'b1,16'h00FF,B_ZP,1'b1,8'h00},
        {8'h00,1'b0,16'h0100,B_ST,1'b0,8'h00},
        {8'h00,1'b0,16'h01FF,B_ST,1'b0,8'h00},
        {8'h00,1'b1,16'h0200,B_LO,1'b1,8'h00},
        {8'h00,1'b0,16'h1FFF,B_LO,1'b0,8'h00},
        {8'h00,1'b1,16'h2000,B_BK,1'b1,8'h00},
        {8'h00,1'b0,16'h9FFF,B_BK,1'b0,8'h00},
        {8'h00,1'b0,16'hA000,B_HI,1'b0,8'h00},
        {8'h00,1'b1,16'hBFFF,B_HI,1'b1,8'h00},
        {8'h00,1'b0,16'hC000,B_SY,1'b0,8'h00},
        {8'h00,1'b1,16'hC0FF,B_SY,1'b1,8'h00},
        {8'h00,1'b1,16'hC100,B_SY,1'b1,8'h00},
        {8'h00,1'b1,16'hC4FF,B_SY,1'b1,8'h00},
        {8'h00,1'b0,16'hC800,B_SY,1'b0,8'h00},
        {8'h00,1'b1,16'hEFFF,B_SY,1'b1,8'h00},
        {8'h00,1'b1,16'hF000,B_SY,1'b1,8'h00},
        {8'h00,1'b1,16'hFFCF,B_SY,1'b1,8'h00},
        {8'h00,1'b1,16'hFFD0,B_P0,1'b0,8'h00},
        {8'h00,1'b0,16'hFFDF,B_P0,1'b0,8'h00},
        {8'h00,1'b1,16'hFFE0,B_P1,1'b0,8'h00},
        {8'h00,1'b0,16'hFFEF,B_P1,1'b0,8'h00},
        {8'h00,1'b1,16'hFFF0,B_SY,1'b1,8'h00},
        {8'h00,1'b0,16'hFFFF,B_SY,1'b0,8'h00},
        // mode 0x48: I/O page and write protection, RAM at top
        {8'h48,1'b0,16'hC000,B_IO,1'b0,8'h00},
        {8'h48,1'b1,16'hC0FF,B_IO,1'b0,8'h00},
        {8'h48,1'b0,16'hC100,B_NO,1'b0,8'hFF},
        {8'h48,1'b1,16'hC4FF,B_NO,1'b0,8'h00},
        {8'h48,1'b1,16'hC500,B_SY,1'b0,8'h00},
        {8'h48,1'b0,16'hC7FF,B_SY,1'b0,8'h00},
        {8'h48,1'b0,16'hC800,B_NO,1'b0,8'hFF},
        {8'h48,1'b1,16'hCFFF,B_NO,1'b0,8'h00},
        {8'h48,1'b1,16'hD000,B_SY,1'b0,8'h00},
        {8'h48,1'b1,16'hF000,B_SY,1'b0,8'h00},
        {8'h48,1'b1,16'hBFFF,B_HI,1'b1,8'h00},
        {8'h48,1'b0,16'hFFD5,B_P0,1'b0,8'h00},
        // mode 0x01: ROM at top
        {8'h01,1'b1,16'hF000,B_RM,1'b0,8'h00},
        {8'h01,1'b0,16'hFFFF,B_RM,1'b0,8'h00},
        {8'h01,1'b0,16'hFFD0,B_P0,1'b0,8'h00},
        {8'h01,1'b1,16'hFFEF,B_P1,1'b0,8'h00},
        {8'h01,1'b1,16'hEFFF,B_SY,1'b1,8'h00},
        {8'h01,1'b1,16'hC000,B_SY,1'b1,8'h00},
        // mode 0x80: slow clock
        {8'h80,1'b0,16'h0000,B_ZP,1'b0,8'h00},
        {8'h80,1'b0,16'hFFF8,B_SY,1'b0,8'h00},
        // mode 0x09: ROM and protection
        {8'h09,1'b1,16'hF000,B_RM,1'b0,8'h00},
        {8'h09,1'b1,16'hD000,B_SY,1'b0,8'h00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(posedge clk);
        #1;
        cfg_we    = 1'b0;
    endtask

    task automatic access(input logic en, input logic we, input logic [15:0] a);
        @(negedge clk);
        cpu_en   = en;
        cpu_we   = we;
        cpu_addr = a;
        #1;
    endtask

    function automatic logic [19:0] model_addr(input logic [9:0] rg, input logic [15:0] a,
                                               input logic [7:0] zp, input logic [7:0] bk);
        logic [15:0] off;
        off = a - 16'h2000;
        case (rg)
            B_ZP:                   return {4'h0, zp, a[7:0]};
            B_BK:                   return {bk[4:0], off[14:0]};
            B_ST, B_LO, B_HI, B_SY: return {4'hF, a};
            default:                return 20'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [9:0] rg);
        case (rg)
            B_ZP:             return "R2";
            B_BK:             return "R4";
            B_ST, B_LO, B_HI: return "R3";
            B_SY:             return "R6";
            B_IO, B_NO:       return "R5";
            B_RM:             return "R7";
            default:          return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] cur_env;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state (R9) seen through the mapping
        access(1'b1, 1'b0, 16'h0034);
        chk("R9 reset zero page", 64'(ram_addr), 64'h0FF34);
        chk("R10 reset slow", 64'(slow_mode), 64'h1);
        access(1'b1, 1'b0, 16'hF800);
        chk("R9 reset ROM on", 64'(region_sel), 64'(B_RM));
        access(1'b1, 1'b0, 16'hC050);
        chk("R9 reset I/O on", 64'(region_sel), 64'(B_IO));
        access(1'b1, 1'b0, 16'h2345);
        chk("R9 reset bank", 64'(ram_addr), 64'h00345);
        access(1'b1, 1'b1, 16'hE000);
        chk("R9 reset protect", 64'({ram_en, ram_we}), 64'h2);

        // Register write timing (R9): old mapping until the edge
        access(1'b1, 1'b0, 16'h0034);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = ZP_T;
        #1;
        chk("R9 page before edge", 64'(ram_addr), 64'h0FF34);
        @(posedge clk);
        #1 cfg_we = 1'b0;
        chk("R2 page after edge", 64'(ram_addr), 64'h01234);

        // cfg_sel 3 ignored (R9)
        cfg_write(2'd3, 8'h00);
        access(1'b1, 1'b0, 16'h0034);
        chk("R9 sel3 page kept", 64'(ram_addr), 64'h01234);
        access(1'b1, 1'b0, 16'hF800);
        chk("R9 sel3 mode kept", 64'(region_sel), 64'(B_RM));

        cfg_write(2'd2, BANK_T);
        cur_env = 8'hFF;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  v_env;
            logic        v_we;
            logic [15:0] v_a;
            logic [9:0]  v_rg;
            logic        v_wex;
            logic [7:0]  v_fill;
            logic [41:0] exp_b;
            logic [41:0] act_b;
            {v_env, v_we, v_a, v_rg, v_wex, v_fill} = VEC[i];
            if (v_env != cur_env) begin
                cfg_write(2'd0, v_env);
                cur_env = v_env;
            end
            access(1'b1, v_we, v_a);
            exp_b = {v_rg, |v_rg, |(v_rg & 10'h03F), v_wex,
                     model_addr(v_rg, v_a, ZP_T, BANK_T), v_fill, v_env[7]};
            act_b = {region_sel, region_valid, ram_en, ram_we, ram_addr, rd_fill, slow_mode};
            chk($sformatf("%s/R1/R10 vector %0d addr %h", req_of(v_rg), i, v_a),
                64'(act_b), 64'(exp_b));
        end

        // Idle bus (R11)
        cfg_write(2'd0, 8'h40);
        access(1'b0, 1'b0, 16'hC100);
        chk("R11 idle read no fill", 64'({ram_en, ram_we, rd_fill}), 64'h0);
        access(1'b0, 1'b1, 16'h0200);
        chk("R11 idle write no we", 64'({ram_en, ram_we}), 64'h0);
        access(1'b1, 1'b0, 16'hC900);
        chk("R11 open read fill", 64'(rd_fill), 64'hFF);
        chk("R10 slow clear", 64'(slow_mode), 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule